// File: doc/BRIEF.md
# Scheduled Square-Wave Pin Generator

This block drives one timing pin from a free-running 64-bit time value counted in clock ticks. Software loads an absolute start time and a half-period (the number of ticks between two successive pin edges), then issues a start command. Once the time reaches the start time, the pin rises. After that it toggles every half-period, which gives a square wave with 50% duty. With 8 ns ticks the output frequency is 1 s / (half-period × 8 ns × 2). A stop command ends the wave and returns the pin low.

Start and stop arrive as bits of a 32-bit command word that is qualified by a valid strobe. Bit 28 requests a start and bit 27 requests a stop. A start is acted on only if two things hold in the cycle of the command: the loaded start time lies strictly in the future, and the half-period is nonzero. Otherwise the command is dropped without any indication. Every edge is found with a greater-or-equal compare, so a rate-trimmed time source that skips tick values still produces each edge. There is one output channel.

Top module: `sched_pin_gen`

## Requirements
- R1: After reset, `pin_out` and `active` are both low. Whenever `active` is low, `pin_out` is low.
- R2: A command with `cmd_valid` high, bit 28 set and bit 27 clear is accepted when the stored start time is strictly greater than `now_ticks` and the stored half-period is nonzero. In the next cycle `active` is high and `pin_out` is low.
- R3: After acceptance, the first edge raises `pin_out` one cycle after the first cycle in which `now_ticks` is greater than or equal to the start time.
- R4: Each later edge toggles `pin_out` one cycle after `now_ticks` first reaches the previous edge time plus the half-period. When `now_ticks` advances by one per cycle, high and low phases each last exactly half-period cycles.
- R5: Edge detection uses greater-or-equal, so a time source that steps over the exact edge value still toggles the pin.
- R6: A start command whose start time is equal to or earlier than `now_ticks` is ignored: `active` and `pin_out` stay as they were.
- R7: A start command while the stored half-period is zero is ignored.
- R8: A command with bit 27 set stops generation. In the next cycle `pin_out` and `active` are low. Stop takes precedence when bits 27 and 28 are both set.
- R9: The start time and half-period are captured when a start is accepted. Register writes during generation do not change the running wave.
- R10: An accepted start while already active restarts the schedule: the pin goes low in the next cycle and the new start time and half-period apply.
- R11: A command word with neither bit 27 nor bit 28 set, or any word while `cmd_valid` is low, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_ticks | input | 64 | Current time in ticks |
| start_wr | input | 1 | Write strobe for the start-time register |
| start_wdata | input | 64 | Start time to store, absolute ticks |
| dur_wr | input | 1 | Write strobe for the half-period register |
| dur_wdata | input | 32 | Half-period to store, ticks between edges |
| cmd_valid | input | 1 | Qualifies `cmd_word` for one cycle |
| cmd_word | input | 32 | Command; bit 28 start, bit 27 stop |
| pin_out | output | 1 | Generated pin level |
| active | output | 1 | High while armed or generating |

## Verification
The wave is first run with a time source that steps by one tick per cycle, which checks both the first edge and the exact half-period spacing. It is then run with a source that steps by two ticks over odd start and half-period values, so edges are only found if the compare is greater-or-equal rather than equality. Start commands are tried with a start time equal to the present time, one in the past, and a zero half-period, which separates a strict future compare from a loose one. Further runs cover register rewrites during generation, a restart while running, a combined start-and-stop word, and an empty word, which together pin down capture behaviour and command priority.

// File: rtl/spg_pkg.sv
package spg_pkg;

    typedef enum logic [1:0] {
        SPG_IDLE    = 2'd0,
        SPG_ARMED   = 2'd1,
        SPG_RUNNING = 2'd2
    } spg_state_e;

    typedef struct packed {
        logic go;
        logic halt;
    } spg_cmd_t;

    function automatic spg_cmd_t spg_decode(input logic [31:0] word,
                                            input int go_bit,
                                            input int halt_bit);
        spg_cmd_t c;
        c.go   = word[go_bit];
        c.halt = word[halt_bit];
        return c;
    endfunction

endpackage

// File: rtl/spg_cfg_regs.sv
module spg_cfg_regs #(
    parameter int TIME_W = 64,
    parameter int DUR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr,
    input  logic [TIME_W-1:0] start_wdata,
    input  logic              dur_wr,
    input  logic [DUR_W-1:0]  dur_wdata,
    output logic [TIME_W-1:0] start_q,
    output logic [DUR_W-1:0]  dur_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            dur_q   <= '0;
        end else begin
            if (start_wr) start_q <= start_wdata;
            if (dur_wr)   dur_q   <= dur_wdata;
        end
    end

endmodule

// File: rtl/spg_cmd_gate.sv
module spg_cmd_gate
    import spg_pkg::*;
#(
    parameter int TIME_W   = 64,
    parameter int DUR_W    = 32,
    parameter int CMD_W    = 32,
    parameter int GO_BIT   = 28,
    parameter int HALT_BIT = 27
) (
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [TIME_W-1:0] now_ticks,
    input  logic [TIME_W-1:0] start_q,
    input  logic [DUR_W-1:0]  dur_q,
    output logic              arm_req,
    output logic              halt_req
);

    localparam int PAD_W = (CMD_W < 32) ? 32 - CMD_W : 0;

    logic [31:0] word32;
    spg_cmd_t    cmd;
    logic        in_future;
    logic        dur_ok;

    generate
        if (CMD_W < 32) begin : g_pad
            assign word32 = {{PAD_W{1'b0}}, cmd_word};
        end else begin : g_cut
            assign word32 = cmd_word[31:0];
        end
    endgenerate

    always_comb begin
        cmd       = spg_decode(word32, GO_BIT, HALT_BIT);
        in_future = start_q > now_ticks;
        dur_ok    = dur_q != '0;
        halt_req  = cmd_valid && cmd.halt;
        arm_req   = cmd_valid && cmd.go && !cmd.halt && in_future && dur_ok;
    end

endmodule

// File: rtl/spg_edge_timer.sv
module spg_edge_timer #(
    parameter int TIME_W = 64,
    parameter int DUR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now_ticks,
    input  logic              load,
    input  logic [TIME_W-1:0] load_time,
    input  logic [DUR_W-1:0]  load_dur,
    input  logic              advance,
    output logic              due,
    output logic [TIME_W-1:0] edge_q
);

    logic [DUR_W-1:0] run_dur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q    <= '0;
            run_dur_q <= '0;
        end else if (load) begin
            edge_q    <= load_time;
            run_dur_q <= load_dur;
        end else if (advance) begin
            edge_q    <= edge_q + TIME_W'(run_dur_q);
        end
    end

    assign due = now_ticks >= edge_q;

endmodule

// File: rtl/spg_pin_ctrl.sv
module spg_pin_ctrl
    import spg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_req,
    input  logic halt_req,
    input  logic due,
    output logic advance,
    output logic pin_out,
    output logic active
);

    spg_state_e state_q;
    logic       pin_q;

    always_comb begin
        advance = (state_q != SPG_IDLE) && due && !halt_req && !arm_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SPG_IDLE;
            pin_q   <= 1'b0;
        end else if (halt_req) begin
            state_q <= SPG_IDLE;
            pin_q   <= 1'b0;
        end else if (arm_req) begin
            state_q <= SPG_ARMED;
            pin_q   <= 1'b0;
        end else if (advance) begin
            state_q <= SPG_RUNNING;
            pin_q   <= ~pin_q;
        end
    end

    assign pin_out = pin_q;
    assign active  = state_q != SPG_IDLE;

endmodule

// File: rtl/sched_pin_gen.sv
module sched_pin_gen
    import spg_pkg::*;
#(
    parameter int TIME_W   = 64,
    parameter int DUR_W    = 32,
    parameter int CMD_W    = 32,
    parameter int GO_BIT   = 28,
    parameter int HALT_BIT = 27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now_ticks,
    input  logic              start_wr,
    input  logic [TIME_W-1:0] start_wdata,
    input  logic              dur_wr,
    input  logic [DUR_W-1:0]  dur_wdata,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              pin_out,
    output logic              active
);

    logic [TIME_W-1:0] start_q;
    logic [DUR_W-1:0]  dur_q;
    logic [TIME_W-1:0] edge_q;
    logic              arm_req;
    logic              halt_req;
    logic              due;
    logic              advance;

    spg_cfg_regs #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .start_wr    (start_wr),
        .start_wdata (start_wdata),
        .dur_wr      (dur_wr),
        .dur_wdata   (dur_wdata),
        .start_q     (start_q),
        .dur_q       (dur_q)
    );

    spg_cmd_gate #(
        .TIME_W(TIME_W), .DUR_W(DUR_W), .CMD_W(CMD_W),
        .GO_BIT(GO_BIT), .HALT_BIT(HALT_BIT)
    ) u_gate (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .now_ticks (now_ticks),
        .start_q   (start_q),
        .dur_q     (dur_q),
        .arm_req   (arm_req),
        .halt_req  (halt_req)
    );

    spg_edge_timer #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .now_ticks (now_ticks),
        .load      (arm_req),
        .load_time (start_q),
        .load_dur  (dur_q),
        .advance   (advance),
        .due       (due),
        .edge_q    (edge_q)
    );

    spg_pin_ctrl u_pin (
        .clk      (clk),
        .rst      (rst),
        .arm_req  (arm_req),
        .halt_req (halt_req),
        .due      (due),
        .advance  (advance),
        .pin_out  (pin_out),
        .active   (active)
    );

endmodule

// File: rtl/spg_chk.sv
module spg_chk #(
    parameter int TIME_W   = 64,
    parameter int DUR_W    = 32,
    parameter int CMD_W    = 32,
    parameter int GO_BIT   = 28,
    parameter int HALT_BIT = 27
) (
    input logic              clk,
    input logic              rst,
    input logic [TIME_W-1:0] now_ticks,
    input logic              cmd_valid,
    input logic [CMD_W-1:0]  cmd_word,
    input logic [TIME_W-1:0] start_q,
    input logic [DUR_W-1:0]  dur_q,
    input logic [TIME_W-1:0] edge_q,
    input logic              pin_out,
    input logic              active
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    logic go_w, halt_w;
    assign go_w   = cmd_valid && cmd_word[GO_BIT];
    assign halt_w = cmd_valid && cmd_word[HALT_BIT];

    // R1
    idle_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !pin_out);

    // R2
    arm_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (go_w && !halt_w && dur_q != '0 && start_q > now_ticks) |=> (active && !pin_out));

    // R6
    past_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && go_w && !halt_w && start_q <= now_ticks) |=> !active);

    // R7
    zero_dur_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && go_w && dur_q == '0) |=> !active);

    // R8
    halt_low_chk: assert property (@(posedge clk) disable iff (rst)
        halt_w |=> (!pin_out && !active));

    // R3
    toggle_when_due_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (active && $past(active) && !$past(cmd_valid) && (pin_out != $past(pin_out)))
        |-> $past(now_ticks >= edge_q));

    // R4
    hold_until_due_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (active && $past(active) && !$past(cmd_valid) && $past(now_ticks < edge_q))
        |-> $stable(pin_out));

endmodule

bind sched_pin_gen spg_chk #(
    .TIME_W(TIME_W), .DUR_W(DUR_W), .CMD_W(CMD_W),
    .GO_BIT(GO_BIT), .HALT_BIT(HALT_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .now_ticks (now_ticks),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .start_q   (start_q),
    .dur_q     (dur_q),
    .edge_q    (edge_q),
    .pin_out   (pin_out),
    .active    (active)
);

// File: tb/sim_sched_pin_gen.sv
`timescale 1ns/1ps
module sim_sched_pin_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] now_r = 64'd1000;
    logic [63:0] step = 64'd1;
    logic        start_wr = 1'b0;
    logic [63:0] start_wdata = '0;
    logic        dur_wr = 1'b0;
    logic [31:0] dur_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        pin_out, active;

    int    n_run = 0;
    int    n_fail = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    int    toggles = 0;

    localparam logic [31:0] W_GO   = 32'h1000_0000; // bit 28
    localparam logic [31:0] W_HALT = 32'h0800_0000; // bit 27

    always #2.5 clk = ~clk;

    sched_pin_gen u0 (
        .clk(clk), .rst(rst), .now_ticks(now_r),
        .start_wr(start_wr), .start_wdata(start_wdata),
        .dur_wr(dur_wr), .dur_wdata(dur_wdata),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .pin_out(pin_out), .active(active)
    );

    // time source moves 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        now_r = now_r + step;
    end

    // behavioural reference, updated on the same edges the design uses
    bit          m_act, m_pin;
    logic [63:0] m_next, m_start_reg;
    logic [31:0] m_dur, m_dur_reg;

    always @(posedge clk) begin
        bit go, halt;
        if (rst) begin
            m_act = 0; m_pin = 0; m_next = 0; m_dur = 0;
            m_start_reg = 0; m_dur_reg = 0;
        end else begin
            go   = cmd_valid && cmd_word[28];
            halt = cmd_valid && cmd_word[27];
            if (halt) begin
                m_act = 0; m_pin = 0;
            end else if (go && m_dur_reg != 0 && m_start_reg > now_r) begin
                m_act = 1; m_pin = 0; m_next = m_start_reg; m_dur = m_dur_reg;
            end else if (m_act && now_r >= m_next) begin
                m_pin = !m_pin;
                m_next = m_next + {32'd0, m_dur};
            end
            if (start_wr) m_start_reg = start_wdata;
            if (dur_wr)   m_dur_reg   = dur_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference, tagged by scenario
    bit last_pin = 0;
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            check(pin_out === m_pin, {tag, " pin"}, int'(pin_out), int'(m_pin));
            check(active === m_act, {tag, " active"}, int'(active), int'(m_act));
            if (pin_out !== last_pin) toggles++;
            last_pin = pin_out;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_start(input logic [63:0] v);
        @(negedge clk); start_wr = 1; start_wdata = v;
        @(negedge clk); start_wr = 0;
    endtask

    task automatic write_dur(input logic [31:0] v);
        @(negedge clk); dur_wr = 1; dur_wdata = v;
        @(negedge clk); dur_wr = 0;
    endtask

    task automatic send_cmd(input logic [31:0] w);
        @(negedge clk); cmd_valid = 1; cmd_word = w;
        @(negedge clk); cmd_valid = 0; cmd_word = '0;
    endtask

    // watchdog
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int t0;
        wait_cycles(4);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1: reset state
        check(pin_out === 1'b0, "R1 reset pin", int'(pin_out), 0);
        check(active === 1'b0, "R1 reset active", int'(active), 0);
        chk_en = 1;

        // R2/R3/R4: normal run, step 1
        tag = "R3";
        write_dur(32'd5);
        write_start(now_r + 64'd20);
        send_cmd(W_GO);
        check(active === 1'b1 && pin_out === 1'b0, "R2 armed", int'(active), 1);
        wait_cycles(20);
        tag = "R4";
        t0 = toggles;
        wait_cycles(40);
        check(toggles - t0 == 8, "R4 toggle count", toggles - t0, 8);

        // R8: stop
        tag = "R8";
        send_cmd(W_HALT);
        check(!pin_out && !active, "R8 stop", int'(active), 0);
        wait_cycles(10);

        // R6: start equal to now (time frozen)
        tag = "R6";
        step = 0;
        wait_cycles(2);
        write_start(now_r);
        send_cmd(W_GO);
        check(active === 1'b0, "R6 equal start ignored", int'(active), 0);
        step = 1;
        write_start(now_r - 64'd50);
        send_cmd(W_GO);
        check(active === 1'b0, "R6 past start ignored", int'(active), 0);

        // R7: zero half-period
        tag = "R7";
        write_dur(32'd0);
        write_start(now_r + 64'd30);
        send_cmd(W_GO);
        check(active === 1'b0, "R7 zero duration ignored", int'(active), 0);

        // R5: time steps by 2 over odd values
        tag = "R5";
        step = 2;
        wait_cycles(2);
        if (now_r[0]) write_dur(32'd3); else write_dur(32'd3);
        write_start({now_r[63:1], 1'b1} + 64'd20);
        send_cmd(W_GO);
        t0 = toggles;
        wait_cycles(40);
        check(toggles - t0 > 10, "R5 skipped ticks still toggle", toggles - t0, 11);

        // R9: rewrites during generation
        tag = "R9";
        step = 1;
        send_cmd(W_HALT);
        write_dur(32'd4);
        write_start(now_r + 64'd10);
        send_cmd(W_GO);
        write_dur(32'd9);
        write_start(now_r + 64'd500);
        wait_cycles(15);
        t0 = toggles;
        wait_cycles(32);
        check(toggles - t0 == 8, "R9 wave unchanged by writes", toggles - t0, 8);

        // R10: restart while active
        tag = "R10";
        write_dur(32'd2);
        write_start(now_r + 64'd12);
        wait_cycles(3);
        send_cmd(W_GO);
        check(active && !pin_out, "R10 restart pin low", int'(pin_out), 0);
        wait_cycles(25);

        // R11: empty word and strobe low
        tag = "R11";
        t0 = toggles;
        @(negedge clk); cmd_word = W_HALT; cmd_valid = 0;
        @(negedge clk); cmd_word = '0;
        send_cmd(32'h0000_0001);
        check(active === 1'b1, "R11 no-op keeps active", int'(active), 1);
        wait_cycles(6);
        check(toggles - t0 >= 2, "R11 wave continues", toggles - t0, 3);

        // R8: both bits, stop wins
        tag = "R8";
        send_cmd(W_GO | W_HALT);
        check(!active && !pin_out, "R8 stop over start", int'(active), 0);
        wait_cycles(5);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule